// File: doc/BRIEF.md
# Sample-Accurate Stream Delay Line

This block delays a wide sample stream by an exact number of samples. The stream carries several consecutive samples per clock in one word (eight by default). The earliest sample of a word sits in lane 0, and lane 0 occupies the lowest bits of the bus. The delay setting counts single samples. Its upper bits select how many whole words to reach back into a short word history. Its lower bits select a shift of 0 to 7 lanes. That shift pulls samples across the seam between the chosen word and the word before it. The total delay is therefore exact to one sample, without a clock running at the sample rate.

The usual use is to set the delay once after start-up. The setting lines up the first generated sample with the first captured sample after a measured path latency. The setting may change while data flows. The new value applies to the next accepted word, with no flush, so the output shows a jump at that point. The history starts at zero, so leading output words carry zeros until real samples reach the selected tap.

Both stream edges use valid/ready. An input word is taken on a cycle where `in_valid` and `in_ready` are both high. Each taken word yields exactly one output word on the next cycle. The output register holds its word while `out_valid` is high and `out_ready` is low. During that hold, `in_ready` is low. `in_ready` is high whenever the output register is empty or is being read in the same cycle. Cycles without a transfer do not advance the delay.

Top module: `sample_delay_line`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1, and the word history holds zeros.
- R2: With delay D = 8*C + F (C from the bits above the low 3, F from the low 3 bits), lane i of the output for the k-th accepted word (k from 0) carries stream sample 8k+i-D.
- R3: Lane i of a word occupies bits [12*i+11 : 12*i] (default 12-bit samples). Lane 0 is the earliest sample of the word.
- R4: Any output lane whose stream index 8k+i-D is negative carries zero.
- R5: With delay 0, the output word for an accepted input word equals that input word, one cycle after acceptance.
- R6: A fine shift F of 1 to 7 fills lanes 0..F-1 from the top lanes of the previous word and lanes F..7 from the current word's lanes 0..7-F.
- R7: A word count C above MAX_WORDS (default 4) is treated as MAX_WORDS. The fine shift still applies, so settings 47 and 63 act as 39.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` keeps its value and `in_ready` is 0, so no input word is taken.
- R9: Each accepted input word produces exactly one output word on the next cycle. If the output is read and no word is accepted, `out_valid` drops to 0. Idle cycles do not change the history.
- R10: A new delay setting takes effect on the next accepted word, using the existing history without a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_data | input | LANES*SAMPLE_W (96) | Input word, lane 0 in the low bits |
| delay | input | DELAY_W (6) | Delay in samples: low 3 bits fine shift, upper bits word count |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | LANES*SAMPLE_W (96) | Delayed output word |

## Verification
A stale or misordered word in the history shows up at the output one cycle after the next accepted word. It appears as a wrong word reached through the coarse tap, or as wrong values in the low lanes of a fine-shifted word. A wrong lane index in the shifter breaks lanes on every word at nonzero fine settings. A history that advances on idle or stalled cycles slips the whole stream by eight samples, visible on the first word after the gap. Flow-control faults show directly as a changed output while stalled, or as a lost or duplicated word.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int DEF_LANES     = 8;
  localparam int DEF_SAMPLE_W  = 12;
  localparam int DEF_MAX_WORDS = 4;
endpackage

// File: rtl/sdl_word_history.sv
module sdl_word_history #(
  parameter int WORD_W = 96,
  parameter int DEPTH  = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         advance,
  input  logic [WORD_W-1:0]            in_word,
  output logic [DEPTH:0][WORD_W-1:0]   taps
);
  // store[0] is the most recently accepted word, store[DEPTH-1] the oldest
  logic [DEPTH-1:0][WORD_W-1:0] store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store <= '0;
    end else if (advance) begin
      store[0] <= in_word;
      for (int j = 1; j < DEPTH; j++) begin
        store[j] <= store[j-1];
      end
    end
  end

  // tap 0 is the word being accepted now; tap j is the word j acceptances back
  always_comb begin
    taps[0] = in_word;
    for (int j = 0; j < DEPTH; j++) begin
      taps[j+1] = store[j];
    end
  end
endmodule

// File: rtl/sdl_lane_shift.sv
module sdl_lane_shift #(
  parameter int LANES    = 8,
  parameter int SAMPLE_W = 12,
  parameter int FINE_W   = 3
) (
  input  logic [LANES*SAMPLE_W-1:0] cur_word,
  input  logic [LANES*SAMPLE_W-1:0] prev_word,
  input  logic [FINE_W-1:0]         fine,
  output logic [LANES*SAMPLE_W-1:0] shifted
);
  localparam int SEL_W = $clog2(2*LANES);

  // joined lanes 0..LANES-1 are the older word, LANES..2*LANES-1 the newer
  logic [2*LANES-1:0][SAMPLE_W-1:0] joined;
  assign joined = {cur_word, prev_word};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel = SEL_W'(LANES + i) - SEL_W'(fine);
    assign shifted[i*SAMPLE_W +: SAMPLE_W] = joined[sel];
  end
endmodule

// File: rtl/sample_delay_line.sv
module sample_delay_line
  import sdl_pkg::*;
#(
  parameter int LANES     = DEF_LANES,
  parameter int SAMPLE_W  = DEF_SAMPLE_W,
  parameter int MAX_WORDS = DEF_MAX_WORDS,
  localparam int WORD_W   = LANES * SAMPLE_W,
  localparam int FINE_W   = $clog2(LANES),
  localparam int DELAY_W  = $clog2((MAX_WORDS + 1) * LANES),
  localparam int COARSE_W = DELAY_W - FINE_W,
  localparam int DEPTH    = MAX_WORDS + 1,
  localparam int TAP_W    = $clog2(MAX_WORDS + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  input  logic [DELAY_W-1:0] delay,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data
);
  logic                          accept;
  logic [COARSE_W-1:0]           coarse_req;
  logic [FINE_W-1:0]             fine;
  logic [TAP_W-1:0]              tap_sel;
  logic [DEPTH:0][WORD_W-1:0]    taps;
  logic [WORD_W-1:0]             cur_word;
  logic [WORD_W-1:0]             prev_word;
  logic [WORD_W-1:0]             shifted;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  assign coarse_req = delay[DELAY_W-1:FINE_W];
  assign fine       = delay[FINE_W-1:0];

  always_comb begin
    if (int'(coarse_req) > MAX_WORDS) tap_sel = TAP_W'(MAX_WORDS);
    else                              tap_sel = TAP_W'(coarse_req);
  end

  sdl_word_history #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept),
    .in_word (in_data),
    .taps    (taps)
  );

  assign cur_word  = taps[tap_sel];
  assign prev_word = taps[tap_sel + TAP_W'(1)];

  sdl_lane_shift #(
    .LANES    (LANES),
    .SAMPLE_W (SAMPLE_W),
    .FINE_W   (FINE_W)
  ) u_shift (
    .cur_word  (cur_word),
    .prev_word (prev_word),
    .fine      (fine),
    .shifted   (shifted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= shifted;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
  parameter int WORD_W  = 96,
  parameter int DELAY_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [WORD_W-1:0]  in_data,
  input logic [DELAY_W-1:0] delay,
  input logic               out_valid,
  input logic               out_ready,
  input logic [WORD_W-1:0]  out_data
);
  // R8: a stalled output word stays put
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: no input taken while the output is stalled
  a_r8_no_take_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: every taken word yields an output word next cycle
  a_r9_word_out: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: a read output with nothing new leaves the output empty
  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

  // R5: zero delay passes the word straight through
  a_r5_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && delay == '0) |=> (out_data == $past(in_data)));
endmodule

bind sample_delay_line sdl_checker #(
  .WORD_W  (WORD_W),
  .DELAY_W (DELAY_W)
) u_chk (.*);

// File: tb/sample_delay_line_tb.sv
module sample_delay_line_tb;
  localparam int LANES  = 8;
  localparam int SW     = 12;
  localparam int MAXW   = 4;
  localparam int WORD_W = LANES * SW;
  localparam int DW     = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [WORD_W-1:0] in_data;
  logic [DW-1:0]     delay;
  logic              out_valid;
  logic              out_ready;
  logic [WORD_W-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sample_delay_line u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .delay(delay), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [SW-1:0] sval(int seed, int idx);
    if (idx < 0) return '0;
    return SW'(seed * 131 + idx * 7 + 1);
  endfunction

  function automatic logic [WORD_W-1:0] word_of(int seed, int k);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < LANES; i++) w[i*SW +: SW] = sval(seed, 8*k + i);
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] expect_word(int seed, int k, int d);
    logic [WORD_W-1:0] w;
    int c = d / 8;
    int f = d % 8;
    int eff;
    if (c > MAXW) c = MAXW;
    eff = 8*c + f;
    for (int i = 0; i < LANES; i++) w[i*SW +: SW] = sval(seed, 8*k + i - eff);
    return w;
  endfunction

  task automatic check_word(string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; delay = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_words(string tag, int seed, int d, int k0, int n);
    for (int k = k0; k < k0 + n; k++) begin
      in_valid = 1'b1; in_data = word_of(seed, k); delay = DW'(d);
      @(negedge clk);
      check_bit({tag, " valid"}, out_valid, 1'b1);
      check_word(tag, out_data, expect_word(seed, k, d));
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    reset_dut();
    check_bit("R1 out_valid", out_valid, 1'b0);
    check_word("R1 out_data", out_data, '0);
    check_bit("R1 in_ready", in_ready, 1'b1);
  endtask

  task automatic t_zero_delay();
    reset_dut();
    run_words("R5 R3 delay0", 1, 0, 0, 4);
  endtask

  task automatic t_fine();
    reset_dut(); run_words("R6 R4 delay1", 2, 1, 0, 4);
    reset_dut(); run_words("R6 R4 delay5", 3, 5, 0, 4);
    reset_dut(); run_words("R6 R2 delay7", 4, 7, 0, 4);
  endtask

  task automatic t_coarse();
    reset_dut(); run_words("R2 R4 delay8", 5, 8, 0, 6);
    reset_dut(); run_words("R2 delay13", 6, 13, 0, 7);
    reset_dut(); run_words("R2 R4 delay39", 7, 39, 0, 8);
  endtask

  task automatic t_clamp();
    reset_dut(); run_words("R7 delay63", 8, 63, 0, 8);
    reset_dut(); run_words("R7 delay47", 9, 47, 0, 8);
  endtask

  task automatic t_backpressure();
    reset_dut();
    run_words("R8 prefill", 10, 3, 0, 3);
    out_ready = 1'b0; in_valid = 1'b1; in_data = word_of(10, 3);
    for (int r = 0; r < 2; r++) begin
      @(negedge clk);
      check_bit("R8 in_ready low", in_ready, 1'b0);
      check_bit("R8 valid held", out_valid, 1'b1);
      check_word("R8 data held", out_data, expect_word(10, 2, 3));
    end
    out_ready = 1'b1;
    @(negedge clk);
    check_word("R8 resume", out_data, expect_word(10, 3, 3));
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_gap();
    reset_dut();
    run_words("R9 before gap", 11, 10, 0, 2);
    for (int g = 0; g < 3; g++) begin
      @(negedge clk);
      check_bit("R9 idle valid low", out_valid, 1'b0);
    end
    run_words("R9 after gap", 11, 10, 2, 4);
  endtask

  task automatic t_change();
    reset_dut();
    run_words("R10 first", 12, 3, 0, 4);
    run_words("R10 changed", 12, 10, 4, 4);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_delay();
    t_fine();
    t_coarse();
    t_clamp();
    t_backpressure();
    t_gap();
    t_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule